// File: doc/BRIEF.md
# Byte Serializer/Deserializer with Loopback Paths

This block moves bytes between a parallel side and a serial side, all inside a single fast clock domain. On the transmit side, a byte-rate strobe loads an 8-bit word into a shift register. The shift register then sends that word out one bit per fast cycle, starting with the most significant bit. On the receive side, a deserializer gathers serial bits and presents each group of eight as a parallel byte, together with a one-cycle byte strobe. While the line is in use, each received bit is qualified by a bit enable. A select input chooses whether that enable comes from a recovered-timing source or from an externally supplied one.

Three mode inputs set up the loopback paths, and they can be combined:

- **Equipment loopback** feeds the serialized transmit stream back into the deserializer. The transmitted bits still leave on the serial output.
- **Pad loopback** replaces the serial receive input with the serial output pin, at the very edge of the receive selection.
- **Facility loopback** echoes the serial receive input onto the serial output.

When equipment and facility loopback are both set, the block enters a split mode. In split mode the serial input goes straight to the serial output, and the parallel transmit byte and its strobe go straight to the parallel receive side. Mode inputs are sampled only at byte boundaries, which are the cycles when the transmit strobe is high. Whenever the receive source changes, the deserializer's bit count restarts.

Top module: `byte_serdes_lb`

## Requirements
- R1: On a clock edge where `tx_stb` is high, `tx_byte` is loaded. In the following eight cycles, `ser_tx_out` carries bits 7 down to 0 of that byte, one bit per cycle. This holds whenever facility loopback is not active.
- R2: With the line as the receive source, each edge with the selected bit enable high samples `ser_rx_in`. After eight sampled bits, `rx_byte` holds them with the first bit in bit 7, and `rx_stb` is high for exactly the one cycle after the edge that sampled the eighth bit.
- R3: `sel_ext_timing`=1 takes the line bit enable from `ext_bit_en`, and `sel_ext_timing`=0 takes it from `rec_bit_en`. The enable that is not selected has no effect on the received bytes.
- R4: With equipment loopback alone, every transmitted byte appears on `rx_byte`, with an `rx_stb` pulse once every 8 cycles on internal timing. `ser_tx_out` still carries the serialized transmit data.
- R5: With facility loopback active, `ser_tx_out` equals `ser_rx_in` delayed by one cycle. With facility loopback alone, the deserializer keeps decoding the line.
- R6: In split mode (equipment and facility loopback both set), `rx_stb` is high in the cycle after each `tx_stb` edge, with `rx_byte` equal to the `tx_byte` captured at that edge. `ser_tx_out` follows R5.
- R7: With pad loopback and no equipment loopback, the deserializer receives `ser_tx_out` on internal timing (a bit every cycle), so the transmitted bytes come back on `rx_byte`.
- R8: The mode inputs are sampled only at edges where `tx_stb` is high. At other edges, a change on the mode inputs has no effect.
- R9: When the receive source changes (line, transmit stream or pad), the bit count restarts at the byte boundary where the change takes effect. A partial line byte is discarded, and a byte completed on that same edge is still delivered.
- R10: Reset (synchronous, active high) clears `ser_tx_out`, `rx_byte`, `rx_stb` and all modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_byte | input | 8 | Parallel transmit word |
| tx_stb | input | 1 | Transmit byte strobe, a divide-by-8 enable; also the mode sampling point |
| ser_rx_in | input | 1 | Serial receive line |
| rec_bit_en | input | 1 | Bit enable from recovered timing |
| ext_bit_en | input | 1 | Bit enable from external receive timing |
| sel_ext_timing | input | 1 | 1 selects `ext_bit_en`, 0 selects `rec_bit_en` |
| equip_lb | input | 1 | Equipment loopback request |
| pad_lb | input | 1 | Pad-level loopback request |
| facil_lb | input | 1 | Facility loopback request |
| ser_tx_out | output | 1 | Serial transmit output |
| rx_byte | output | 8 | Parallel receive word |
| rx_stb | output | 1 | One-cycle receive byte strobe |

## Verification
The line path is driven with a dense bit stream, and again with gaps in which the unselected enable pulses over inverted data. Only a correct enable select then yields the right byte. Equipment and pad loopback send distinct bytes, which tests bit ordering and byte alignment on internal timing. Loopback is entered after a deliberate 3-bit partial line byte, so a missing count restart shows up as shifted bytes. Facility and split modes run line and transmit traffic with different bytes at the same time, which separates the serial echo from the parallel bypass and shows that each path carries its own data.

// File: rtl/serdes_lb_pkg.sv
package serdes_lb_pkg;

    typedef enum logic [1:0] {
        SRC_LINE = 2'd0,
        SRC_XMIT = 2'd1,
        SRC_PAD  = 2'd2
    } rx_src_e;

    typedef struct packed {
        logic equip;
        logic pad;
        logic facil;
    } lb_mode_t;

    function automatic logic is_split(lb_mode_t m);
        return m.equip & m.facil;
    endfunction

    // Equipment loopback (non-split) wins over pad loopback.
    function automatic rx_src_e pick_src(lb_mode_t m);
        if (m.equip && !m.facil) return SRC_XMIT;
        if (m.pad)               return SRC_PAD;
        return SRC_LINE;
    endfunction

endpackage

// File: rtl/sl_mode_ctrl.sv
module sl_mode_ctrl
    import serdes_lb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     byte_stb,
    input  lb_mode_t mode_in,
    output lb_mode_t mode_q,
    output rx_src_e  src_q,
    output logic     src_clear
);
    rx_src_e src_next;

    always_comb begin
        src_next  = pick_src(mode_in);
        src_clear = byte_stb && (src_next != src_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            src_q  <= SRC_LINE;
        end else if (byte_stb) begin
            mode_q <= mode_in;
            src_q  <= src_next;
        end
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !byte_stb |=> $stable(mode_q)); // R8

endmodule

// File: rtl/sl_tx_serializer.sv
module sl_tx_serializer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic         bit_out
);
    logic [W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst)       shreg <= '0;
        else if (load) shreg <= din;
        else           shreg <= {shreg[W-2:0], 1'b0};
    end

    assign bit_out = shreg[W-1];

    AST_TX_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> bit_out == $past(din[W-1])); // R1

endmodule

// File: rtl/sl_rx_deserializer.sv
module sl_rx_deserializer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_en,
    input  logic         bit_in,
    input  logic         clear,
    output logic [W-1:0] byte_out,
    output logic         byte_stb
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0]  sh;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            cnt      <= '0;
            byte_out <= '0;
            byte_stb <= 1'b0;
        end else begin
            byte_stb <= 1'b0;
            if (bit_en) begin
                sh <= {sh[W-2:0], bit_in};
                if (cnt == LAST) begin
                    byte_out <= {sh[W-2:0], bit_in};
                    byte_stb <= 1'b1;
                    cnt      <= '0;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
            if (clear) cnt <= '0;
        end
    end

    AST_STB_AFTER_BIT: assert property (@(posedge clk) disable iff (rst)
        byte_stb |-> $past(bit_en)); // R2

endmodule

// File: rtl/byte_serdes_lb.sv
module byte_serdes_lb
    import serdes_lb_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] tx_byte,
    input  logic         tx_stb,
    input  logic         ser_rx_in,
    input  logic         rec_bit_en,
    input  logic         ext_bit_en,
    input  logic         sel_ext_timing,
    input  logic         equip_lb,
    input  logic         pad_lb,
    input  logic         facil_lb,
    output logic         ser_tx_out,
    output logic [W-1:0] rx_byte,
    output logic         rx_stb
);
    lb_mode_t     mode_in, mode_q;
    rx_src_e      src_q;
    logic         src_clear;
    logic         tx_bit;
    logic         echo_q;
    logic [W-1:0] byp_byte;
    logic         byp_stb;
    logic         line_en, des_en, des_bit;
    logic [W-1:0] des_byte;
    logic         des_stb;

    assign mode_in = '{equip: equip_lb, pad: pad_lb, facil: facil_lb};

    sl_mode_ctrl u_mode (
        .clk      (clk),
        .rst      (rst),
        .byte_stb (tx_stb),
        .mode_in  (mode_in),
        .mode_q   (mode_q),
        .src_q    (src_q),
        .src_clear(src_clear)
    );

    sl_tx_serializer #(.W(W)) u_ser (
        .clk    (clk),
        .rst    (rst),
        .load   (tx_stb),
        .din    (tx_byte),
        .bit_out(tx_bit)
    );

    // Facility echo and parallel bypass registers
    always_ff @(posedge clk) begin
        if (rst) begin
            echo_q   <= 1'b0;
            byp_byte <= '0;
            byp_stb  <= 1'b0;
        end else begin
            echo_q  <= ser_rx_in;
            byp_stb <= tx_stb;
            if (tx_stb) byp_byte <= tx_byte;
        end
    end

    assign ser_tx_out = mode_q.facil ? echo_q : tx_bit;

    // Receive source and bit-timing selection
    always_comb begin
        line_en = sel_ext_timing ? ext_bit_en : rec_bit_en;
        unique case (src_q)
            SRC_XMIT: begin des_bit = tx_bit;     des_en = 1'b1;    end
            SRC_PAD:  begin des_bit = ser_tx_out; des_en = 1'b1;    end
            default:  begin des_bit = ser_rx_in;  des_en = line_en; end
        endcase
    end

    sl_rx_deserializer #(.W(W)) u_des (
        .clk     (clk),
        .rst     (rst),
        .bit_en  (des_en),
        .bit_in  (des_bit),
        .clear   (src_clear),
        .byte_out(des_byte),
        .byte_stb(des_stb)
    );

    assign rx_byte = is_split(mode_q) ? byp_byte : des_byte;
    assign rx_stb  = is_split(mode_q) ? byp_stb  : des_stb;

    AST_FAC_ECHO: assert property (@(posedge clk) disable iff (rst)
        (mode_q.facil && $past(mode_q.facil)) |-> ser_tx_out == $past(ser_rx_in)); // R5

    AST_SPLIT_BYTE: assert property (@(posedge clk) disable iff (rst)
        (is_split(mode_q) && rx_stb) |-> rx_byte == $past(tx_byte)); // R6

endmodule

// File: tb/byte_serdes_lb_tb.sv
module byte_serdes_lb_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] tx_byte = '0;
    logic       tx_stb = 1'b0;
    logic       ser_rx_in = 1'b0;
    logic       rec_bit_en = 1'b0;
    logic       ext_bit_en = 1'b0;
    logic       sel_ext_timing = 1'b0;
    logic       equip_lb = 1'b0, pad_lb = 1'b0, facil_lb = 1'b0;
    logic       ser_tx_out;
    logic [7:0] rx_byte;
    logic       rx_stb;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    byte_serdes_lb u_dut (
        .clk(clk), .rst(rst), .tx_byte(tx_byte), .tx_stb(tx_stb),
        .ser_rx_in(ser_rx_in), .rec_bit_en(rec_bit_en), .ext_bit_en(ext_bit_en),
        .sel_ext_timing(sel_ext_timing), .equip_lb(equip_lb), .pad_lb(pad_lb),
        .facil_lb(facil_lb), .ser_tx_out(ser_tx_out), .rx_byte(rx_byte), .rx_stb(rx_stb)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
        end
    endtask

    // Scoreboard monitor: every receive strobe pops one expected byte (R2 R4 R6 R7)
    always @(negedge clk) begin
        if (!rst && !done && rx_stb) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected rx_stb", rx_byte, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(rx_byte == e, "R2/R4/R6/R7 rx_byte", rx_byte, e);
            end
        end
    end

    // Called at a negedge; strobes one byte and spans exactly 8 cycles (R1, R8)
    task automatic tx_frame(input logic [7:0] b, input bit eq, input bit pd,
                            input bit fc, input bit chk);
        tx_byte = b; tx_stb = 1'b1;
        equip_lb = eq; pad_lb = pd; facil_lb = fc;
        @(negedge clk);
        tx_stb = 1'b0;
        equip_lb = ~eq; pad_lb = ~pd; facil_lb = ~fc; // R8: ignored off-boundary
        tx_byte = ~b;
        for (int i = 7; i >= 0; i--) begin
            if (chk) check(ser_tx_out == b[i], "R1 ser_tx_out bit", ser_tx_out, b[i]);
            if (i > 0) @(negedge clk);
        end
        equip_lb = eq; pad_lb = pd; facil_lb = fc;
    endtask

    // Drives one line byte, MSB first; noise inserts cycles with the other enable (R3)
    task automatic line_byte(input logic [7:0] b, input bit sel, input bit noise,
                             input bit chkfac);
        sel_ext_timing = sel;
        for (int i = 7; i >= 0; i--) begin
            ser_rx_in = b[i];
            if (sel) begin ext_bit_en = 1'b1; rec_bit_en = 1'b0; end
            else     begin rec_bit_en = 1'b1; ext_bit_en = 1'b0; end
            @(negedge clk);
            if (chkfac) check(ser_tx_out == b[i], "R5 facility echo", ser_tx_out, b[i]);
            if (noise) begin
                ser_rx_in = ~b[i];
                if (sel) begin ext_bit_en = 1'b0; rec_bit_en = 1'b1; end
                else     begin rec_bit_en = 1'b0; ext_bit_en = 1'b1; end
                @(negedge clk);
            end
        end
        rec_bit_en = 1'b0; ext_bit_en = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        check(ser_tx_out == 1'b0, "R10 ser_tx_out", ser_tx_out, 0);
        check(rx_stb == 1'b0, "R10 rx_stb", rx_stb, 0);
        check(rx_byte == 8'h00, "R10 rx_byte", rx_byte, 0);

        // Normal mode: independent paths, recovered timing (R1, R2)
        exp_q.push_back(8'h3C);
        fork
            tx_frame(8'hA5, 0, 0, 0, 1);
            line_byte(8'h3C, 0, 0, 0);
        join
        // External timing with noise on the unselected enable (R3)
        exp_q.push_back(8'hC3);
        fork
            tx_frame(8'h5A, 0, 0, 0, 1);
            line_byte(8'hC3, 1, 1, 0);
        join
        // Recovered timing with noise on ext enable (R3)
        exp_q.push_back(8'h69);
        line_byte(8'h69, 0, 1, 0);

        // R9: leave a 3-bit partial line byte, then enter equipment loopback
        sel_ext_timing = 1'b0;
        for (int i = 0; i < 3; i++) begin
            ser_rx_in = 1'b1; rec_bit_en = 1'b1;
            @(negedge clk);
        end
        rec_bit_en = 1'b0;
        @(negedge clk);

        // R4 equipment loopback; R9 last byte completes at the exit edge
        exp_q.push_back(8'h11);
        exp_q.push_back(8'h2E);
        exp_q.push_back(8'hF0);
        tx_frame(8'h11, 1, 0, 0, 1);
        tx_frame(8'h2E, 1, 0, 0, 1);
        tx_frame(8'hF0, 1, 0, 0, 1);
        tx_frame(8'h96, 0, 0, 0, 1);
        // R9: line counter starts fresh after the source change
        exp_q.push_back(8'h81);
        line_byte(8'h81, 0, 0, 0);
        @(negedge clk);

        // R5 facility alone: echo plus normal line decoding
        exp_q.push_back(8'h6E);
        fork
            tx_frame(8'h00, 0, 0, 1, 0);
            line_byte(8'h6E, 0, 0, 1);
        join
        exp_q.push_back(8'h17);
        fork
            tx_frame(8'hFF, 0, 0, 1, 0);
            line_byte(8'h17, 1, 0, 1);
        join

        // R6 split mode: parallel bypass and serial echo together
        exp_q.push_back(8'hDE);
        fork
            tx_frame(8'hDE, 1, 0, 1, 0);
            line_byte(8'h44, 0, 0, 1);
        join
        exp_q.push_back(8'hAD);
        fork
            tx_frame(8'hAD, 1, 0, 1, 0);
            line_byte(8'h99, 0, 0, 1);
        join
        tx_frame(8'h00, 0, 0, 0, 1);

        // R7 pad loopback alone
        exp_q.push_back(8'h3B);
        exp_q.push_back(8'hC4);
        tx_frame(8'h3B, 0, 1, 0, 1);
        tx_frame(8'hC4, 0, 1, 0, 1);
        tx_frame(8'h00, 0, 0, 0, 1);

        repeat (12) @(negedge clk);
        check(exp_q.size() == 0, "R2/R4 all expected bytes seen", exp_q.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule